// File: doc/BRIEF.md
# Reference Clock Alarm Event Recorder

This block supervises four alarm levels from a clock-synchronization subsystem: loss of the primary reference, loss of the secondary reference, PLL holdover and PLL unlock. Each level is brought into the local clock domain through a multi-stage synchronizer. Every change of a synchronized level, in either direction, sets its own sticky bit in an 8-bit event byte. While any event bit is set, an interrupt line is held high.

Software sees the block through a byte-wide window of eight registers on a simple read/write bus. Read data is combinational from the address. The window shows the live alarm levels, the latched events, which reference the PLL is tracking, a writable reference-select bit and a fixed interrupt-number field. A read of the event byte returns its contents and clears them. An edge that lands in the same cycle as that read is kept for the next read.

Top module: `refmon_event_unit`

## Requirements
- R1: After reset the event byte reads 0x00, `irq_o` is low and `ref_sel_o` is 0, which selects the primary reference.
- R2: A 0-to-1 change of alarm input i sets event bit 2i. The input bits are 0 primary lost, 1 secondary lost, 2 holdover and 3 unlock.
- R3: A 1-to-0 change of alarm input i sets event bit 2i+1.
- R4: Event bits stay set until the event byte is read, however long the alarm stays at its new level.
- R5: A read at offset 6 returns the event byte. The bits that were read are cleared at the clock edge that ends the read.
- R6: `irq_o` is high whenever the event byte is non-zero. It falls in the cycle after a clearing read that coincides with no new edge.
- R7: An edge detected in the cycle of a clearing read is not lost. It is the content of the event byte after the read.
- R8: Offset 2 shows the synchronized live levels in bits 7..4: bit 7 primary lost, bit 6 secondary lost, bit 5 holdover, bit 4 unlock. Bits 3..0 read 0.
- R9: Offset 1 bit 3 shows the synchronized `trk_sec_i`. Offset 1 bit 0 is the read/write reference select, driven on `ref_sel_o`.
- R10: Offset 7 reads {4'b0, IRQ_NUM}. Offsets 0, 3, 4 and 5 read 0x00.
- R11: Writes to any offset other than 1 have no effect. So do writes to any bit of offset 1 other than bit 0.
- R12: No event is recorded for alarm levels already present when reset is released. Each transition produces exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_i | input | 4 | Asynchronous alarm levels (0 pri lost, 1 sec lost, 2 holdover, 3 unlock) |
| trk_sec_i | input | 1 | Asynchronous indicator: PLL tracking the secondary reference |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt, high while any event is pending |
| ref_sel_o | output | 1 | Reference select, 0 primary, 1 secondary |

## Verification
The assertions assume that read and write strobes are never high in the same cycle. They also assume that every read strobe lasts exactly one clock, so a clearing read covers exactly one edge. The alarm inputs are free to change at any time, because the properties watch only the synchronized and edge-detected signals. The bench drives every strobe for one cycle, between falling edges. It holds each alarm level for several cycles longer than the synchronizer depth, except in the test that places an edge on the clearing read.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
   localparam int unsigned NUM_ALARM = 4;
   localparam int unsigned EVT_W     = 2 * NUM_ALARM;
   localparam int unsigned REG_W     = 8;
   localparam int unsigned OFF_W     = 3;

   localparam int unsigned ALM_PRI    = 0;
   localparam int unsigned ALM_SEC    = 1;
   localparam int unsigned ALM_HOLD   = 2;
   localparam int unsigned ALM_UNLOCK = 3;

   typedef enum logic [OFF_W-1:0] {
      OFF_RSV0   = 3'd0,
      OFF_REFCTL = 3'd1,
      OFF_LEVEL  = 3'd2,
      OFF_RSV3   = 3'd3,
      OFF_RSV4   = 3'd4,
      OFF_RSV5   = 3'd5,
      OFF_EVENT  = 3'd6,
      OFF_IDENT  = 3'd7
   } refmon_off_e;

   localparam int unsigned REFCTL_SEL_BIT = 0;
   localparam int unsigned REFCTL_TRK_BIT = 3;
endpackage

// File: rtl/refmon_sync.sv
module refmon_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("refmon_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar k = 1; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/refmon_edge.sv
module refmon_edge #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned SETTLE = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   localparam int unsigned CNT_W = $clog2(SETTLE + 1) + 1;

   logic [WIDTH-1:0] prev_q;
   logic [CNT_W-1:0] settle_q;
   logic             armed;

   assign armed = (settle_q == CNT_W'(SETTLE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         settle_q <= '0;
      end else begin
         prev_q <= lvl;
         if (!armed) settle_q <= settle_q + 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_det
         assign rise[i] = armed &  lvl[i] & ~prev_q[i];
         assign fall[i] = armed & ~lvl[i] &  prev_q[i];
      end
   endgenerate
endmodule

// File: rtl/refmon_evreg.sv
module refmon_evreg #(
   parameter int unsigned NALM = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NALM-1:0]   rise,
   input  logic [NALM-1:0]   fall,
   input  logic              clr,
   output logic [2*NALM-1:0] ev_new,
   output logic [2*NALM-1:0] ev_q,
   output logic              irq
);
   generate
      for (genvar i = 0; i < NALM; i++) begin : g_pair
         assign ev_new[2*i]   = rise[i];
         assign ev_new[2*i+1] = fall[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ev_q <= '0;
      else if (clr) ev_q <= ev_new;
      else          ev_q <= ev_q | ev_new;
   end

   assign irq = |ev_q;
endmodule

// File: rtl/refmon_regwin.sv
module refmon_regwin
   import refmon_pkg::*;
#(
   parameter logic [3:0] IRQ_NUM = 4'hA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OFF_W-1:0] bus_addr,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [REG_W-1:0] bus_wdata,
   input  logic [NUM_ALARM-1:0] lvl,
   input  logic             trk_sec,
   input  logic [EVT_W-1:0] ev_q,
   output logic             ev_clr,
   output logic [REG_W-1:0] bus_rdata,
   output logic             ref_sel
);
   logic unused_wbits;
   assign unused_wbits = ^bus_wdata[REG_W-1:1];

   assign ev_clr = bus_rd && (bus_addr == OFF_EVENT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ref_sel <= 1'b0;
      else if (bus_wr && (bus_addr == OFF_REFCTL)) ref_sel <= bus_wdata[REFCTL_SEL_BIT];
   end

   logic [REG_W-1:0] refctl_v, level_v, ident_v;

   always_comb begin
      refctl_v = '0;
      refctl_v[REFCTL_SEL_BIT] = ref_sel;
      refctl_v[REFCTL_TRK_BIT] = trk_sec;
      level_v = {lvl[ALM_PRI], lvl[ALM_SEC], lvl[ALM_HOLD], lvl[ALM_UNLOCK], 4'b0000};
      ident_v = {4'b0000, IRQ_NUM};
   end

   always_comb begin
      unique case (refmon_off_e'(bus_addr))
         OFF_REFCTL: bus_rdata = refctl_v;
         OFF_LEVEL:  bus_rdata = level_v;
         OFF_EVENT:  bus_rdata = ev_q;
         OFF_IDENT:  bus_rdata = ident_v;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/refmon_event_unit.sv
module refmon_event_unit
   import refmon_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [3:0]  IRQ_NUM     = 4'hA
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_ALARM-1:0] alarm_i,
   input  logic                 trk_sec_i,
   input  logic [OFF_W-1:0]     bus_addr,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic [REG_W-1:0]     bus_wdata,
   output logic [REG_W-1:0]     bus_rdata,
   output logic                 irq_o,
   output logic                 ref_sel_o
);
   localparam int unsigned SYNC_W = NUM_ALARM + 1;
   localparam int unsigned SETTLE = SYNC_STAGES + 1;

   generate
      if (EVT_W != REG_W) begin : g_bad_width
         $error("refmon_event_unit: event byte must fill one register");
      end
   endgenerate

   logic [SYNC_W-1:0]    sync_q;
   logic [NUM_ALARM-1:0] lvl, evt_rise, evt_fall;
   logic                 trk_sec;
   logic [EVT_W-1:0]     ev_new, ev_q;
   logic                 ev_clr;

   refmon_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({trk_sec_i, alarm_i}), .q(sync_q)
   );

   assign lvl     = sync_q[NUM_ALARM-1:0];
   assign trk_sec = sync_q[NUM_ALARM];

   refmon_edge #(.WIDTH(NUM_ALARM), .SETTLE(SETTLE)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(evt_rise), .fall(evt_fall)
   );

   refmon_evreg #(.NALM(NUM_ALARM)) u_evreg (
      .clk(clk), .rst_n(rst_n), .rise(evt_rise), .fall(evt_fall),
      .clr(ev_clr), .ev_new(ev_new), .ev_q(ev_q), .irq(irq_o)
   );

   refmon_regwin #(.IRQ_NUM(IRQ_NUM)) u_win (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .lvl(lvl), .trk_sec(trk_sec),
      .ev_q(ev_q), .ev_clr(ev_clr), .bus_rdata(bus_rdata), .ref_sel(ref_sel_o)
   );
endmodule

// File: rtl/refmon_event_unit_chk.sv
module refmon_event_unit_chk #(
   parameter logic [3:0] IRQ_NUM = 4'hA
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] bus_addr,
   input logic       bus_rd,
   input logic       bus_wr,
   input logic [7:0] bus_wdata,
   input logic [7:0] bus_rdata,
   input logic       irq_o,
   input logic       ref_sel_o,
   input logic [7:0] ev_new,
   input logic [7:0] ev_q
);
   logic rd_evt;
   assign rd_evt = bus_rd && (bus_addr == 3'd6);

   assert_clear_keeps_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_evt |=> (ev_q == $past(ev_new)));

   assert_irq_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_evt && ev_new == 8'h00) |=> !irq_o);

   assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_evt |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

   assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(ev_new) != 8'h00));

   assert_sel_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd1) |=> (ref_sel_o == $past(bus_wdata[0])));

   assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == 3'd1) |=> $stable(ref_sel_o));

   assert_ident_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 3'd7) |-> (bus_rdata == {4'b0000, IRQ_NUM}));
endmodule

bind refmon_event_unit refmon_event_unit_chk #(.IRQ_NUM(IRQ_NUM)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .irq_o(irq_o), .ref_sel_o(ref_sel_o), .ev_new(ev_new), .ev_q(ev_q)
);

// File: tb/refmon_event_unit_bench.sv
module refmon_event_unit_bench;
   localparam logic [3:0] TB_IRQ = 4'h9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] alarm_i = 4'hF;
   logic       trk_sec_i = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq_o, ref_sel_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   refmon_event_unit #(.SYNC_STAGES(2), .IRQ_NUM(TB_IRQ)) u_refmon_event_unit (
      .clk(clk), .rst_n(rst_n), .alarm_i(alarm_i), .trk_sec_i(trk_sec_i),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
      .ref_sel_o(ref_sel_o)
   );

   // {alarm levels, expected event byte}; bit 2i rise, 2i+1 fall
   localparam logic [11:0] VEC [9] = '{
      {4'b0001, 8'h01}, {4'b0000, 8'h02}, {4'b0110, 8'h14},
      {4'b1001, 8'h69}, {4'b1111, 8'h14}, {4'b0000, 8'hAA},
      {4'b0000, 8'h00}, {4'b1000, 8'h40}, {4'b0000, 8'h80}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      // R1 / R12: reset with all alarms already high
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(8);
      check("R1 irq after reset", {7'b0, irq_o}, 8'h00);
      check("R1 sel after reset", {7'b0, ref_sel_o}, 8'h00);
      bus_read(3'd6, d); check("R12 no event for levels present at reset", d, 8'h00);
      bus_read(3'd2, d); check("R8 levels all high", d, 8'hF0);

      // drop all: four falls
      @(negedge clk); alarm_i = 4'b0000;
      wait_cyc(5);
      bus_read(3'd6, d); check("R3 all falls", d, 8'hAA);
      wait_cyc(1);

      // table walk R2 R3 R5 R6 R8
      for (int k = 0; k < 9; k++) begin
         @(negedge clk); alarm_i = VEC[k][11:8];
         wait_cyc(5);
         check("R6 irq follows pending events", {7'b0, irq_o}, {7'b0, VEC[k][7:0] != 8'h00});
         bus_read(3'd2, d);
         check("R8 live level nibble", d,
               {VEC[k][8], VEC[k][9], VEC[k][10], VEC[k][11], 4'b0000});
         bus_read(3'd6, d); check("R2 R3 event byte", d, VEC[k][7:0]);
         check("R5 irq low after clearing read", {7'b0, irq_o}, 8'h00);
         bus_read(3'd6, d); check("R5 event byte cleared", d, 8'h00);
      end

      // R4: sticky across a long hold, then both directions present
      @(negedge clk); alarm_i[2] = 1'b1;
      wait_cyc(40);
      check("R4 irq held", {7'b0, irq_o}, 8'h01);
      @(negedge clk); alarm_i[2] = 1'b0;
      wait_cyc(5);
      bus_read(3'd6, d); check("R4 both holdover edges kept", d, 8'h30);

      // R7: edge coinciding with clearing read
      @(negedge clk); alarm_i[0] = 1'b1;
      wait_cyc(5);
      @(negedge clk); alarm_i[1] = 1'b1;
      @(negedge clk);
      bus_read(3'd6, d); check("R7 read returns older event", d, 8'h01);
      check("R7 irq still high", {7'b0, irq_o}, 8'h01);
      wait_cyc(3);
      bus_read(3'd6, d); check("R7 coincident edge retained", d, 8'h04);
      @(negedge clk); alarm_i = 4'b0000;
      wait_cyc(5);
      bus_read(3'd6, d); check("R12 one event per transition", d, 8'h0A);

      // R9: tracking indicator and select bit
      @(negedge clk); trk_sec_i = 1'b1;
      wait_cyc(4);
      bus_read(3'd1, d); check("R9 tracking bit", d, 8'h08);
      bus_write(3'd1, 8'h01);
      check("R9 select output", {7'b0, ref_sel_o}, 8'h01);
      bus_read(3'd1, d); check("R9 select readback", d, 8'h09);

      // R11: writes elsewhere ignored
      bus_write(3'd1, 8'hFE);
      bus_read(3'd1, d); check("R11 only bit0 writable", d, 8'h08);
      bus_write(3'd1, 8'h01);
      bus_write(3'd6, 8'hFF);
      check("R11 event write no irq", {7'b0, irq_o}, 8'h00);
      bus_read(3'd6, d); check("R11 event write ignored", d, 8'h00);
      bus_write(3'd7, 8'hFF);
      bus_write(3'd2, 8'hFF);
      bus_write(3'd0, 8'hFE);
      check("R11 select kept", {7'b0, ref_sel_o}, 8'h01);
      bus_read(3'd2, d); check("R11 level write ignored", d, 8'h00);

      // R10: identity and reserved offsets
      bus_read(3'd7, d); check("R10 interrupt number", d, {4'b0000, TB_IRQ});
      bus_read(3'd0, d); check("R10 offset 0", d, 8'h00);
      bus_read(3'd3, d); check("R10 offset 3", d, 8'h00);
      bus_read(3'd4, d); check("R10 offset 4", d, 8'h00);
      bus_read(3'd5, d); check("R10 offset 5", d, 8'h00);

      // R1: reset again clears select
      @(negedge clk); rst_n = 1'b0;
      wait_cyc(2);
      check("R1 select reset", {7'b0, ref_sel_o}, 8'h00);
      rst_n = 1'b1;
      wait_cyc(2);
      finish_run();
   end
endmodule